// File: doc/BRIEF.md
# Reset and Strap-Option Start-Up Sequencer

This block brings an audio interface device up from reset in a fixed order. While the active-low reset input is held low, every piece of internal state is cleared and the audio outputs stay muted. The block keeps its strap-capable pins in the input direction and holds the device in low power. Once reset is released, the block samples the levels on those shared pins a single time, then turns them back into outputs. One of the sampled levels supplies the least significant bit of the control-port device address.

After reset, software reaches a small synchronous register bus. The control register holds a run bit, and a read-only identity register returns a 4-bit device code together with a 4-bit revision code. Setting the run bit takes the device out of low power. The audio enable is then held off until the PLL-lock and rate-converter-settled status inputs are both true. If either status input drops while audio is enabled, the outputs are muted again until both return. Clearing the run bit puts the device back into low power.

Top module: `audio_startup_ctrl`

## Requirements
- R1: While the internal reset is asserted, `audio_en` is 0, `lowpower` is 1, every bit of `strap_oe` is 0, and the control register reads 0x00.
- R2: The reset input passes through a two-flop synchroniser. Strap levels are captured on the first clock edge after the synchronised release, which is the third rising edge after `rst_n` goes high, and `strap_oe` becomes all ones on that same edge. Changes on `strap_in` after that edge have no effect on `strap_val`.
- R3: `dev_addr` equals the parameter `BUS_ADDR_BASE` with bit 0 replaced by the latched level of strap bit `ADDR_STRAP` (0x51 or 0x50 with the defaults).
- R4: After reset release, `lowpower` stays 1 and `audio_en` stays 0 until the run bit is written to 1.
- R5: The run bit is bit 0 of the control register at address 0. Its other bits read 0. A write of 1 shows on readback after the write edge, and `lowpower` falls one edge later.
- R6: `audio_en` rises only once run is set and both `pll_locked` and `src_settled` have been seen high on a clock edge. It rises on the edge that sees both high.
- R7: While audio is enabled, if either status input is low on an edge, `audio_en` falls on that edge and `lowpower` stays 0. `audio_en` rises again on the first edge that sees both inputs high.
- R8: Writing 0 to the run bit drops `audio_en` and raises `lowpower` one edge after the write edge.
- R9: Address 1 reads {ID code, revision code} (0xA3 with the defaults), and writes to it have no effect.
- R10: Addresses 2 and 3 read 0x00, and writes to them change neither register nor the sequencer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset request, asynchronous to clk |
| reg_addr | input | 2 | Register bus address |
| reg_wdata | input | 8 | Register bus write data |
| reg_we | input | 1 | Register bus write strobe |
| reg_rdata | output | 8 | Register bus read data, combinational from address |
| pll_locked | input | 1 | PLL lock indication |
| src_settled | input | 1 | Rate converter settled indication |
| strap_in | input | 4 | Levels sensed on the shared strap pins |
| strap_oe | output | 4 | Per-pin output enables for the strap pins |
| strap_val | output | 4 | Strap levels latched at start-up |
| dev_addr | output | 7 | Control-port device address |
| lowpower | output | 1 | Low-power request to the rest of the device |
| audio_en | output | 1 | Enable for the transmitter and serial audio outputs |

## Verification
A sequencer stuck in the wrong state shows up at the ports within one clock edge. If it enables audio too early, `audio_en` is high while a status input or the run bit is low. If it is stuck in reset, `strap_oe` stays low and `lowpower` stays high after the third edge. If it never leaves low power, `lowpower` is still high two edges after run is written. A capture strobe that fires at the wrong time, or fires again, leaves `strap_val` and `dev_addr` different from the levels present on the third edge after release. It also lets later pin changes leak into `strap_val`.

// File: rtl/audio_startup_pkg.sv
package audio_startup_pkg;

    localparam int REG_AW = 2;
    localparam int REG_DW = 8;

    localparam logic [REG_AW-1:0] REG_CTRL  = 2'd0;
    localparam logic [REG_AW-1:0] REG_IDENT = 2'd1;

    localparam int CTRL_RUN_BIT = 0;

    typedef enum logic [1:0] {
        ST_RESET   = 2'd0,
        ST_IDLE_LP = 2'd1,
        ST_WAIT    = 2'd2,
        ST_RUN     = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic locked;
        logic settled;
    } clk_status_t;

    typedef struct packed {
        logic run;
    } ctrl_reg_t;

    function automatic logic status_ok(input clk_status_t s);
        return s.locked & s.settled;
    endfunction

    function automatic seq_state_e seq_next(
        input seq_state_e  cur,
        input logic        run,
        input clk_status_t st
    );
        seq_state_e nxt;
        nxt = cur;
        unique case (cur)
            ST_RESET:   nxt = ST_IDLE_LP;
            ST_IDLE_LP: nxt = run ? ST_WAIT : ST_IDLE_LP;
            ST_WAIT: begin
                if (!run)               nxt = ST_IDLE_LP;
                else if (status_ok(st)) nxt = ST_RUN;
                else                    nxt = ST_WAIT;
            end
            ST_RUN: begin
                if (!run)                nxt = ST_IDLE_LP;
                else if (!status_ok(st)) nxt = ST_WAIT;
                else                     nxt = ST_RUN;
            end
            default:    nxt = ST_RESET;
        endcase
        return nxt;
    endfunction

    function automatic logic [REG_DW-1:0] read_mux(
        input logic [REG_AW-1:0] addr,
        input ctrl_reg_t         ctrl,
        input logic [3:0]        id_code,
        input logic [3:0]        rev_code
    );
        logic [REG_DW-1:0] d;
        d = '0;
        unique case (addr)
            REG_CTRL:  d[CTRL_RUN_BIT] = ctrl.run;
            REG_IDENT: d = {id_code, rev_code};
            default:   d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rst_syncer.sv
module rst_syncer #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_int
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], rst_n};
    end

    assign rst_int = ~chain[STAGES-1];
endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
    parameter int N_STRAP = 4
) (
    input  logic               clk,
    input  logic               rst_int,
    input  logic               capture,
    input  logic [N_STRAP-1:0] pin_in,
    output logic [N_STRAP-1:0] pin_oe,
    output logic [N_STRAP-1:0] latched
);
    for (genvar i = 0; i < N_STRAP; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst_int) begin
                pin_oe[i]  <= 1'b0;
                latched[i] <= 1'b0;
            end else if (capture) begin
                pin_oe[i]  <= 1'b1;
                latched[i] <= pin_in[i];
            end
        end
    end
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
    import audio_startup_pkg::*;
#(
    parameter logic [3:0] ID_CODE  = 4'hA,
    parameter logic [3:0] REV_CODE = 4'h3
) (
    input  logic              clk,
    input  logic              rst_int,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    input  logic              we,
    output logic [REG_DW-1:0] rdata,
    output ctrl_reg_t         ctrl
);
    logic unused_wbits;
    assign unused_wbits = ^{wdata[REG_DW-1:CTRL_RUN_BIT+1]};

    always_ff @(posedge clk) begin
        if (rst_int) begin
            ctrl.run <= 1'b0;
        end else if (we && addr == REG_CTRL) begin
            ctrl.run <= wdata[CTRL_RUN_BIT];
        end
    end

    assign rdata = read_mux(addr, ctrl, ID_CODE, REV_CODE);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import audio_startup_pkg::*;
(
    input  logic        clk,
    input  logic        rst_int,
    input  logic        run,
    input  clk_status_t status,
    output seq_state_e  state,
    output logic        capture
);
    always_ff @(posedge clk) begin
        if (rst_int) state <= ST_RESET;
        else         state <= seq_next(state, run, status);
    end

    assign capture = !rst_int && (state == ST_RESET);
endmodule

// File: rtl/audio_startup_ctrl.sv
module audio_startup_ctrl
    import audio_startup_pkg::*;
#(
    parameter int         N_STRAP       = 4,
    parameter int         ADDR_STRAP    = 0,
    parameter logic [6:0] BUS_ADDR_BASE = 7'h50,
    parameter logic [3:0] ID_CODE       = 4'hA,
    parameter logic [3:0] REV_CODE      = 4'h3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    input  logic               reg_we,
    output logic [7:0]         reg_rdata,
    input  logic               pll_locked,
    input  logic               src_settled,
    input  logic [N_STRAP-1:0] strap_in,
    output logic [N_STRAP-1:0] strap_oe,
    output logic [N_STRAP-1:0] strap_val,
    output logic [6:0]         dev_addr,
    output logic               lowpower,
    output logic               audio_en
);
    logic        rst_int;
    logic        capture;
    ctrl_reg_t   ctrl;
    clk_status_t status;
    seq_state_e  state;

    rst_syncer #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_int (rst_int)
    );

    ctrl_regs #(.ID_CODE(ID_CODE), .REV_CODE(REV_CODE)) u_regs (
        .clk     (clk),
        .rst_int (rst_int),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .we      (reg_we),
        .rdata   (reg_rdata),
        .ctrl    (ctrl)
    );

    assign status.locked  = pll_locked;
    assign status.settled = src_settled;

    seq_fsm u_fsm (
        .clk     (clk),
        .rst_int (rst_int),
        .run     (ctrl.run),
        .status  (status),
        .state   (state),
        .capture (capture)
    );

    strap_latch #(.N_STRAP(N_STRAP)) u_straps (
        .clk     (clk),
        .rst_int (rst_int),
        .capture (capture),
        .pin_in  (strap_in),
        .pin_oe  (strap_oe),
        .latched (strap_val)
    );

    assign dev_addr = {BUS_ADDR_BASE[6:1], strap_val[ADDR_STRAP]};
    assign lowpower = (state == ST_RESET) || (state == ST_IDLE_LP);
    assign audio_en = (state == ST_RUN);
endmodule

// File: rtl/audio_startup_ctrl_chk.sv
module audio_startup_ctrl_chk #(
    parameter int N_STRAP = 4
) (
    input logic               clk,
    input logic               rst_int,
    input logic               run_q,
    input logic               pll_locked,
    input logic               src_settled,
    input logic [N_STRAP-1:0] strap_oe,
    input logic [N_STRAP-1:0] strap_val,
    input logic               lowpower,
    input logic               audio_en
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst_int |=> (!audio_en && lowpower && strap_oe == '0)); // R1

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (rst_int)
        (strap_oe[0] && $past(strap_oe[0])) |-> $stable(strap_val)); // R2

    AST_OE_UNIFORM: assert property (@(posedge clk) disable iff (rst_int)
        (strap_oe == '0) || (strap_oe == '1)); // R2

    AST_LOWPOWER_EXCL: assert property (@(posedge clk) disable iff (rst_int)
        !(lowpower && audio_en)); // R4

    AST_AUDIO_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst_int)
        $rose(audio_en) |-> $past(run_q)); // R5

    AST_AUDIO_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst_int)
        audio_en |-> $past(pll_locked && src_settled)); // R6

    AST_AUDIO_DROPS: assert property (@(posedge clk) disable iff (rst_int)
        (audio_en && !(pll_locked && src_settled)) |=> !audio_en); // R7

    AST_RUN_CLEAR: assert property (@(posedge clk) disable iff (rst_int)
        (!run_q && $past(!run_q)) |-> lowpower); // R8
endmodule

bind audio_startup_ctrl audio_startup_ctrl_chk #(.N_STRAP(N_STRAP)) u_chk (
    .clk         (clk),
    .rst_int     (rst_int),
    .run_q       (ctrl.run),
    .pll_locked  (pll_locked),
    .src_settled (src_settled),
    .strap_oe    (strap_oe),
    .strap_val   (strap_val),
    .lowpower    (lowpower),
    .audio_en    (audio_en)
);

// File: tb/audio_startup_ctrl_bench.sv
module audio_startup_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;
    logic       pll_locked;
    logic       src_settled;
    logic [3:0] strap_in;
    logic [3:0] strap_oe;
    logic [3:0] strap_val;
    logic [6:0] dev_addr;
    logic       lowpower;
    logic       audio_en;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;

    audio_startup_ctrl u_audio_startup_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .pll_locked(pll_locked),
        .src_settled(src_settled), .strap_in(strap_in), .strap_oe(strap_oe),
        .strap_val(strap_val), .dev_addr(dev_addr), .lowpower(lowpower),
        .audio_en(audio_en)
    );

    // row: {req, we, addr, wdata, lock, settled, exp_lowpower, exp_audio, exp_rdata}
    localparam int NV = 19;
    localparam logic [26:0] VEC [NV] = '{
        {4'd4,  1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00}, // R4 idle with good status
        {4'd5,  1'b1, 2'd0, 8'h01, 1'b1, 1'b1, 1'b1, 1'b0, 8'h01}, // R5 write run
        {4'd5,  1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h01}, // R5 low power left
        {4'd6,  1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h01}, // R6 audio on
        {4'd7,  1'b0, 2'd1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA3}, // R7 lock lost
        {4'd7,  1'b0, 2'd1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA3}, // R7 settle low
        {4'd7,  1'b0, 2'd1, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'hA3}, // R7 recovered
        {4'd9,  1'b1, 2'd1, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 8'hA3}, // R9 ident write ignored
        {4'd10, 1'b1, 2'd2, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00}, // R10 unmapped
        {4'd8,  1'b1, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00}, // R8 clear run
        {4'd8,  1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00}, // R8 back to low power
        {4'd5,  1'b1, 2'd0, 8'h03, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01}, // R5 reserved bits read 0
        {4'd6,  1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01}, // R6 waiting
        {4'd6,  1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h01}, // R6 settle only
        {4'd6,  1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h01}, // R6 both
        {4'd10, 1'b1, 2'd3, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00}, // R10 unmapped 3
        {4'd10, 1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h01}, // R10 run untouched
        {4'd8,  1'b1, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00}, // R8 clear again
        {4'd8,  1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00}  // R8 idle
    };

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00; reg_we = 1'b0;
        pll_locked = 1'b0; src_settled = 1'b0; strap_in = 4'b1011;
        step(4);
        // R1 reset state
        chk("R1", "audio_en", {7'd0, audio_en}, 8'h00);
        chk("R1", "lowpower", {7'd0, lowpower}, 8'h01);
        chk("R1", "strap_oe", {4'd0, strap_oe}, 8'h00);
        chk("R1", "ctrl", reg_rdata, 8'h00);
        reg_we = 1'b1; reg_wdata = 8'h01;   // write attempt held in reset
        step(1);
        reg_we = 1'b0;
        chk("R1", "ctrl under reset", reg_rdata, 8'h00);

        rst_n = 1'b1;
        step(2);
        chk("R2", "oe before sync", {4'd0, strap_oe}, 8'h00);
        step(1);
        chk("R2", "oe after capture", {4'd0, strap_oe}, 8'h0F);
        chk("R2", "strap_val", {4'd0, strap_val}, 8'h0B);
        chk("R3", "dev_addr", {1'b0, dev_addr}, 8'h51);
        strap_in = 4'b0100;
        step(3);
        chk("R2", "strap_val frozen", {4'd0, strap_val}, 8'h0B);
        chk("R4", "lowpower held", {7'd0, lowpower}, 8'h01);
        chk("R4", "audio held", {7'd0, audio_en}, 8'h00);

        for (int v = 0; v < NV; v++) begin
            logic [26:0] r;
            string tag;
            r = VEC[v];
            tag = $sformatf("R%0d", r[26:23]);
            reg_we = r[22]; reg_addr = r[21:20]; reg_wdata = r[19:12];
            pll_locked = r[11]; src_settled = r[10];
            step(1);
            chk(tag, $sformatf("row %0d lowpower", v), {7'd0, lowpower}, {7'd0, r[9]});
            chk(tag, $sformatf("row %0d audio_en", v), {7'd0, audio_en}, {7'd0, r[8]});
            chk(tag, $sformatf("row %0d rdata", v), reg_rdata, r[7:0]);
        end
        reg_we = 1'b0; reg_addr = 2'd0;

        // reset while running: R1 again, then new strap capture for R3
        reg_we = 1'b1; reg_wdata = 8'h01;
        step(1);
        reg_we = 1'b0;
        step(2);
        chk("R6", "running before reset", {7'd0, audio_en}, 8'h01);
        strap_in = 4'b0100;
        rst_n = 1'b0;
        step(3);
        chk("R1", "audio after reset", {7'd0, audio_en}, 8'h00);
        chk("R1", "lowpower after reset", {7'd0, lowpower}, 8'h01);
        chk("R1", "oe after reset", {4'd0, strap_oe}, 8'h00);
        chk("R1", "run cleared", reg_rdata, 8'h00);
        rst_n = 1'b1;
        step(3);
        chk("R2", "recapture", {4'd0, strap_val}, 8'h04);
        chk("R3", "dev_addr low", {1'b0, dev_addr}, 8'h50);
        step(2);
        chk("R4", "no auto restart", {7'd0, audio_en}, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule